// File: doc/BRIEF.md
# Buffered Single-Channel Pulse-Width Modulator

This block produces one pulse-width modulated output from an up or up/down counter. The counter advances once per cycle in which the clock-enable tick is high. An external prescaler supplies that tick, so the counting rate can be set outside this block. The counter is compared with an active period value and an active duty value. A polarity input selects whether the duty value marks the end of the low part or the end of the high part of each cycle. An alignment input selects edge-aligned counting (0) or centre-aligned counting (1).

The host writes period and duty values into holding registers. While the channel runs, the holding values move into the active compare registers only when the counter returns to zero. A new setting therefore never cuts a cycle short or stretches it. While the channel is disabled, a write goes straight to the active registers, the counter rests at zero and the output sits at its idle level. The alignment mode should be chosen before the channel is enabled.

Top module: `pwm_channel`

## Requirements
- R1: After a synchronous reset, with enable and polarity low, the output is 0 and the active period and duty are 0.
- R2: While enable is low, the output equals the polarity input regardless of ticks, and period/duty writes reach the active registers at once.
- R3: In edge-aligned mode the counter advances only on cycles with tick high, runs 0 to period−1 and wraps, so one output cycle spans `period` ticks.
- R4: With polarity 0 the output is low while count < duty and high from the duty match to the end of the cycle, giving period−duty high ticks per cycle.
- R5: With polarity 1 the output is the complement of R4: high while count < duty, giving duty high ticks per cycle.
- R6: A write made while enabled leaves the running cycle unchanged and takes effect from the next counter return to zero.
- R7: Duty 0 makes the active phase fill the whole cycle. Duty ≥ period makes the output stay at the polarity level for the whole cycle.
- R8: An active period of 0 holds the counter at zero and the output at the polarity level.
- R9: In centre-aligned mode the count rises 0..period−1, then falls period..1, so one cycle spans 2·period ticks. The phase is active on the rise when count ≥ duty and on the fall when count > duty, giving 2·(period−duty) active ticks.
- R10: In centre-aligned mode the holding values move into the active registers only when the falling count reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable that advances the counter |
| en | input | 1 | Channel enable |
| pol | input | 1 | Polarity: 0 = low first, 1 = high first |
| center | input | 1 | Alignment: 0 = edge-aligned, 1 = centre-aligned |
| per_wr | input | 1 | Period write strobe |
| per_data | input | W | Period write value |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | W | Duty write value |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with the default 8-bit width. This allows a period of 255, the largest value the counter holds, to be run next to the smallest periods of 0 and 1. With this width, duty values at, above and just below the period can be reached in both alignment modes. Centre-aligned cycles of up to 510 ticks stay short enough to be counted tick by tick.

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en,
  input  logic         pol,
  input  logic         center,
  input  logic         per_wr,
  input  logic [W-1:0] per_data,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_data,
  output logic         pwm_out
);

  logic [W-1:0] per_buf, duty_buf, per_act, duty_act, cnt;
  logic         dn;
  logic [W-1:0] cnt_nx, per_m1;
  logic         dn_nx, wrap, zero_per, phase;

  assign zero_per = (per_act == '0);
  assign per_m1   = per_act - 1'b1;

  always_comb begin
    cnt_nx = cnt;
    dn_nx  = dn;
    wrap   = 1'b0;
    if (zero_per) begin
      cnt_nx = '0;
      dn_nx  = 1'b0;
      wrap   = 1'b1;
    end else if (!center) begin
      dn_nx = 1'b0;
      if (cnt >= per_m1) begin
        cnt_nx = '0;
        wrap   = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else if (!dn) begin
      if (cnt >= per_m1) begin
        cnt_nx = per_act;
        dn_nx  = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else if (cnt <= W'(1)) begin
      cnt_nx = '0;
      dn_nx  = 1'b0;
      wrap   = 1'b1;
    end else begin
      cnt_nx = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf  <= '0;
      duty_buf <= '0;
      per_act  <= '0;
      duty_act <= '0;
      cnt      <= '0;
      dn       <= 1'b0;
    end else begin
      if (per_wr)  per_buf  <= per_data;
      if (duty_wr) duty_buf <= duty_data;
      if (!en) begin
        cnt <= '0;
        dn  <= 1'b0;
        if (per_wr)  per_act  <= per_data;
        if (duty_wr) duty_act <= duty_data;
      end else if (tick) begin
        cnt <= cnt_nx;
        dn  <= dn_nx;
        if (wrap) begin
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end
      end
    end
  end

  assign phase   = en && !zero_per && (dn ? (cnt > duty_act) : (cnt >= duty_act));
  assign pwm_out = pol ^ phase;

  // R2: a disabled channel parks its counter
  assert_idle_count_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0) && !dn);

  // R3: without a tick nothing moves
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt) && $stable(per_act) && $stable(duty_act));

  // R3: rising count stays below the period
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !zero_per && !dn) |-> (cnt < per_act));

  // R6 / R10: active values change only at a return to zero
  assert_load_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (!$stable(duty_act) || !$stable(per_act))) |-> (cnt == '0) && !dn);

  // R9: centre count never passes the period
  assert_center_peak_R9: assert property (@(posedge clk) disable iff (rst)
    (en && center) |-> (cnt <= per_act));

endmodule

// File: tb/pwm_channel_test.sv
module pwm_channel_test;
  logic       clk = 1'b0;
  logic       rst, tick, en, pol, center, per_wr, duty_wr;
  logic [7:0] per_data, duty_data;
  logic       pwm_out;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_channel #(.W(8)) uut (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .pol(pol), .center(center),
    .per_wr(per_wr), .per_data(per_data), .duty_wr(duty_wr), .duty_data(duty_data),
    .pwm_out(pwm_out)
  );

  // {center, pol, period, duty, expected high ticks over one cycle}
  localparam logic [26:0] VEC [14] = '{
    {1'b0, 1'b0, 8'd4,   8'd1,   9'd3},
    {1'b0, 1'b1, 8'd4,   8'd1,   9'd1},
    {1'b0, 1'b0, 8'd10,  8'd3,   9'd7},
    {1'b0, 1'b1, 8'd10,  8'd3,   9'd3},
    {1'b0, 1'b0, 8'd255, 8'd128, 9'd127},
    {1'b0, 1'b1, 8'd255, 8'd254, 9'd254},
    {1'b0, 1'b0, 8'd6,   8'd0,   9'd6},
    {1'b0, 1'b0, 8'd6,   8'd6,   9'd0},
    {1'b0, 1'b1, 8'd6,   8'd9,   9'd6},
    {1'b0, 1'b0, 8'd1,   8'd0,   9'd1},
    {1'b1, 1'b0, 8'd4,   8'd1,   9'd6},
    {1'b1, 1'b1, 8'd5,   8'd2,   9'd4},
    {1'b1, 1'b0, 8'd1,   8'd0,   9'd2},
    {1'b1, 1'b0, 8'd3,   8'd3,   9'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic c, input logic p, input logic [7:0] pr, input logic [7:0] dt);
    @(posedge clk); #1;
    en = 1'b0; center = c; pol = p;
    per_wr = 1'b1; duty_wr = 1'b1; per_data = pr; duty_data = dt;
    @(posedge clk); #1;
    per_wr = 1'b0; duty_wr = 1'b0;
  endtask

  task automatic start();
    @(posedge clk); #1;
    en = 1'b1;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    string tag;
    rst = 1'b1; tick = 1'b1; en = 1'b0; pol = 1'b0; center = 1'b0;
    per_wr = 1'b0; duty_wr = 1'b0; per_data = '0; duty_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state, then an enabled run with untouched registers stays at level 0
    @(negedge clk);
    check("R1 output after reset", int'(pwm_out), 0);
    start();
    measure(4, hi);
    check("R1 zero active period after reset", hi, 0);

    // R2: disabled output follows polarity
    @(posedge clk); #1 en = 1'b0; pol = 1'b1;
    measure(3, hi);
    check("R2 idle high with polarity 1", hi, 3);
    @(posedge clk); #1 pol = 1'b0;
    measure(3, hi);
    check("R2 idle low with polarity 0", hi, 0);

    // R4 R5 R7 R9: table of cycles, each loaded directly while disabled (R2)
    for (int i = 0; i < 14; i++) begin
      logic       c, p;
      logic [7:0] pr, dt;
      logic [8:0] ex;
      {c, p, pr, dt, ex} = VEC[i];
      if (c) tag = "R9";
      else if (dt == 0 || dt >= pr) tag = "R7";
      else if (p) tag = "R5";
      else tag = "R4";
      cfg(c, p, pr, dt);
      start();
      measure(c ? 2 * int'(pr) : int'(pr), hi);
      check($sformatf("%s vector %0d", tag, i), hi, int'(ex));
    end

    // R3: repeating edge-aligned cycle
    cfg(1'b0, 1'b0, 8'd4, 8'd1);
    start();
    measure(8, hi);
    check("R3 two consecutive cycles", hi, 6);

    // R3: counter frozen without tick
    cfg(1'b0, 1'b0, 8'd4, 8'd2);
    @(posedge clk); #1 en = 1'b1; tick = 1'b0;
    measure(4, hi);
    check("R3 no advance without tick", hi, 0);
    @(posedge clk); #1 tick = 1'b1;
    measure(4, hi);
    check("R3 advance once tick returns", hi, 2);

    // R6: duty written while running waits for the next cycle
    cfg(1'b0, 1'b0, 8'd4, 8'd1);
    @(posedge clk); #1 en = 1'b1; duty_wr = 1'b1; duty_data = 8'd3;
    measure(1, hi);
    begin
      int rest;
      @(posedge clk); #1 duty_wr = 1'b0;
      measure(3, rest);
      check("R6 running cycle keeps old duty", hi + rest, 3);
    end
    measure(4, hi);
    check("R6 next cycle uses new duty", hi, 1);

    // R10: centre-aligned load at zero
    cfg(1'b1, 1'b0, 8'd4, 8'd1);
    @(posedge clk); #1 en = 1'b1; duty_wr = 1'b1; duty_data = 8'd3;
    measure(1, hi);
    begin
      int rest;
      @(posedge clk); #1 duty_wr = 1'b0;
      measure(7, rest);
      check("R10 centre cycle keeps old duty", hi + rest, 6);
    end
    measure(8, hi);
    check("R10 centre cycle after reload", hi, 2);

    // R8: zero period
    cfg(1'b0, 1'b0, 8'd0, 8'd0);
    start();
    measure(5, hi);
    check("R8 zero period polarity 0", hi, 0);
    cfg(1'b0, 1'b1, 8'd0, 8'd0);
    start();
    measure(5, hi);
    check("R8 zero period polarity 1", hi, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule